// File: doc/BRIEF.md
# Asynchronous SRAM cycle controller

This block sits between a synchronous host and an external asynchronous static RAM of 2M x 8. The RAM has an active-low chip select, an active-high chip select, an active-low output enable, an active-low write enable and a bidirectional byte-wide data bus. The host offers one request at a time over a valid/ready handshake: a read or write flag, an address and, for writes, one data byte. The controller turns each accepted request into a RAM cycle whose phases last a whole number of clock cycles. Each phase is long enough to meet the RAM's access, pulse-width, data-setup and bus turn-off limits.

The nanosecond limits of two speed grades are built in, and a parameter picks the grade. The clock period is a parameter as well. Each limit becomes a cycle count by rounding up, with a floor of one cycle. All RAM-side pins come from flops. The data bus is presented as separate output, output-enable and input pins, and the pad ring or the bench merges them into one bus.

After reset the controller holds off all accesses for a power-up interval. Whenever no access is running, the RAM is left deselected, which places it in standby. A standby request input keeps the controller from accepting work. When that input is released, the controller waits one read-cycle time before it accepts a new access. Read data is delivered with a one-cycle valid pulse.

Top module: `sram_cycle_ctrl`

## Requirements
- R1: From reset release, req_ready_o is low and the RAM pins are inactive for PWR_CYC = ceil(POWERUP_NS*1000/CLK_PS) rising edges. Inactive means ram_ce_n_o=1, ram_ce_o=0, ram_oe_n_o=1, ram_we_n_o=1 and ram_dq_oe_o=0. Requests made during this time are ignored. req_ready_o first reads high after the PWR_CYC-th edge.
- R2: Every phase length is ceil(limit_ns*1000/CLK_PS) cycles and at least 1. The limits are:
  - SPEED_FAST=1: cycle time 45 ns, address access 45 ns, output-enable access 22 ns, write pulse 35 ns.
  - SPEED_FAST=0: the same four limits are 55, 55, 25 and 40 ns.
  - Both grades: data setup 28 ns and bus turn-off 18 ns.
  - At the defaults (4 ns clock, fast grade): read = 12 cycles, write pulse = 12 cycles, turn-off = 5 cycles, recovery = 12 cycles.
- R3: An accepted read holds the address with ram_ce_n_o=0, ram_ce_o=1, ram_oe_n_o=0 and ram_we_n_o=1 for RD_CYC cycles from the accepting edge. RD_CYC is the largest of the cycle-time, address-access and output-enable-access counts. ram_dq_i is sampled at the edge that ends the last of these cycles. rd_valid_o is then high for exactly one cycle, with that byte on rd_data_o. The address never changes while the RAM is selected.
- R4: An accepted write drives ram_we_n_o low for WP_CYC cycles from the accepting edge. WP_CYC is the largest of three values: the pulse count, the turn-off count plus the setup count, and the write-cycle count minus one. Both chip selects and the address are held for one further cycle with ram_we_n_o high. ram_we_n_o is low only while both chip selects are active.
- R5: ram_dq_oe_o rises HZ_CYC edges after ram_we_n_o falls, where HZ_CYC is the turn-off count. It stays high until one cycle after ram_we_n_o rises. Write data is therefore driven for WP_CYC-HZ_CYC cycles before the rising edge of ram_we_n_o.
- R6: ram_dq_oe_o is never high while ram_oe_n_o is low, and ram_oe_n_o and ram_we_n_o are never low together. Every access is followed by one cycle with the RAM deselected before the next access starts. req_ready_o returns RD_CYC cycles after a read is accepted and WP_CYC+1 cycles after a write is accepted.
- R7: While no access runs, the RAM is deselected and the bus is not driven. While standby_i is high in idle, req_ready_o is low and requests are ignored: no chip select is asserted and the memory contents are unchanged.
- R8: After standby_i falls, req_ready_o stays low for RC_CYC+1 rising edges, where RC_CYC is the cycle-time count, and then rises.
- R9: A request is taken at a rising edge only when req_valid_i and req_ready_o are both high. req_ready_o is low from the edge that accepts a request until the access ends.
- R10: Over the whole address space, a read returns the byte most recently written to that address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Controller clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| standby_i | input | 1 | Hold the RAM in standby and refuse requests |
| req_valid_i | input | 1 | Host request present |
| req_ready_o | output | 1 | Controller idle and able to take a request |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | ADDR_W | Word address |
| req_wdata_i | input | DATA_W | Write byte |
| rd_valid_o | output | 1 | One-cycle pulse: rd_data_o holds read data |
| rd_data_o | output | DATA_W | Captured read byte |
| ram_addr_o | output | ADDR_W | RAM address |
| ram_ce_n_o | output | 1 | RAM select, active low |
| ram_ce_o | output | 1 | RAM select, active high |
| ram_oe_n_o | output | 1 | RAM output enable, active low |
| ram_we_n_o | output | 1 | RAM write enable, active low |
| ram_dq_o | output | DATA_W | Byte driven onto the RAM bus |
| ram_dq_oe_o | output | 1 | 1 = controller drives the RAM bus |
| ram_dq_i | input | DATA_W | Byte read from the RAM bus |

## Verification
The assertions assume three things about the inputs:
- every input changes only away from the rising clock edge;
- the request fields stay steady while req_valid_i waits for req_ready_o;
- standby_i is synchronous to clk_i.

The bench drives every input at falling edges from tasks, holds the fields until the accepting edge, and drops req_valid_i at the next falling edge. Its RAM responder returns valid data only 45 ns after the read address and enables settle. It also treats the bus as still driven by the RAM for 18 ns after a read ends. A short access or an early bus drive therefore shows up as wrong data or as a bus conflict.

// File: rtl/sram_ctrl_pkg.sv
`timescale 1ns/1ps
package sram_ctrl_pkg;

  typedef enum logic [2:0] {
    ST_PWRUP,
    ST_IDLE,
    ST_RD,
    ST_WR_HZ,
    ST_WR_DRV,
    ST_WR_END,
    ST_SLEEP,
    ST_RCV
  } state_e;

  // round a nanosecond limit up to whole clock cycles, never below one
  function automatic int unsigned ns2cyc(int unsigned ns, int unsigned clk_ps);
    int unsigned c;
    c = (ns * 1000 + clk_ps - 1) / clk_ps;
    return (c == 0) ? 1 : c;
  endfunction

  function automatic int unsigned maxu(int unsigned a, int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sram_phase_timer.sv
`timescale 1ns/1ps
module sram_phase_timer #(
  parameter int unsigned CNT_W   = 16,
  parameter int unsigned RST_VAL = 0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic             zero_o
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           cnt_q <= CNT_W'(RST_VAL);
    else if (load_i)       cnt_q <= load_val_i;
    else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);

endmodule

// File: rtl/sram_cycle_fsm.sv
`timescale 1ns/1ps
module sram_cycle_fsm import sram_ctrl_pkg::*; #(
  parameter int unsigned CNT_W   = 16,
  parameter int unsigned PWR_CYC = 1,
  parameter int unsigned RD_CYC  = 1,
  parameter int unsigned HZ_CYC  = 1,
  parameter int unsigned WP_CYC  = 2,
  parameter int unsigned RC_CYC  = 1
) (
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   standby_i,
  input  logic   req_valid_i,
  input  logic   req_write_i,
  output logic   req_ready_o,
  output logic   take_o,
  output logic   rd_done_o,
  output state_e state_d_o
);

  localparam logic [CNT_W-1:0] LD_RD  = CNT_W'(RD_CYC - 1);
  localparam logic [CNT_W-1:0] LD_HZ  = CNT_W'(HZ_CYC - 1);
  localparam logic [CNT_W-1:0] LD_DRV = CNT_W'(WP_CYC - HZ_CYC - 1);
  localparam logic [CNT_W-1:0] LD_RC  = CNT_W'(RC_CYC - 1);

  state_e           state_q, state_d;
  logic             load;
  logic [CNT_W-1:0] load_val;
  logic             zero;

  sram_phase_timer #(
    .CNT_W  (CNT_W),
    .RST_VAL(PWR_CYC - 1)
  ) i_timer (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (load),
    .load_val_i(load_val),
    .zero_o    (zero)
  );

  assign req_ready_o = (state_q == ST_IDLE) && !standby_i;
  assign take_o      = req_ready_o && req_valid_i;

  always_comb begin
    state_d   = state_q;
    load      = 1'b0;
    load_val  = '0;
    rd_done_o = 1'b0;
    unique case (state_q)
      ST_PWRUP:  if (zero) state_d = ST_IDLE;
      ST_IDLE: begin
        if (standby_i) begin
          state_d = ST_SLEEP;
        end else if (take_o) begin
          load = 1'b1;
          if (req_write_i) begin
            state_d  = ST_WR_HZ;
            load_val = LD_HZ;
          end else begin
            state_d  = ST_RD;
            load_val = LD_RD;
          end
        end
      end
      ST_RD: begin
        if (zero) begin
          rd_done_o = 1'b1;
          state_d   = ST_IDLE;
        end
      end
      // write enable low, bus still left to the RAM
      ST_WR_HZ: begin
        if (zero) begin
          state_d  = ST_WR_DRV;
          load     = 1'b1;
          load_val = LD_DRV;
        end
      end
      ST_WR_DRV: if (zero) state_d = ST_WR_END;
      ST_WR_END: state_d = ST_IDLE;
      ST_SLEEP: begin
        if (!standby_i) begin
          state_d  = ST_RCV;
          load     = 1'b1;
          load_val = LD_RC;
        end
      end
      ST_RCV:  if (zero) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_PWRUP;
    else         state_q <= state_d;
  end

  assign state_d_o = state_d;

endmodule

// File: rtl/sram_pin_regs.sv
`timescale 1ns/1ps
module sram_pin_regs import sram_ctrl_pkg::*; #(
  parameter int unsigned ADDR_W = 21,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  state_e            state_d_i,
  input  logic              take_i,
  input  logic              rd_done_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  input  logic [DATA_W-1:0] ram_dq_i,
  output logic [ADDR_W-1:0] ram_addr_o,
  output logic              ram_ce_n_o,
  output logic              ram_ce_o,
  output logic              ram_oe_n_o,
  output logic              ram_we_n_o,
  output logic [DATA_W-1:0] ram_dq_o,
  output logic              ram_dq_oe_o,
  output logic              rd_valid_o,
  output logic [DATA_W-1:0] rd_data_o
);

  logic sel_d;
  assign sel_d = state_d_i inside {ST_RD, ST_WR_HZ, ST_WR_DRV, ST_WR_END};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ram_ce_n_o  <= 1'b1;
      ram_ce_o    <= 1'b0;
      ram_oe_n_o  <= 1'b1;
      ram_we_n_o  <= 1'b1;
      ram_dq_oe_o <= 1'b0;
    end else begin
      ram_ce_n_o  <= !sel_d;
      ram_ce_o    <= sel_d;
      ram_oe_n_o  <= !(state_d_i == ST_RD);
      ram_we_n_o  <= !(state_d_i inside {ST_WR_HZ, ST_WR_DRV});
      ram_dq_oe_o <= state_d_i inside {ST_WR_DRV, ST_WR_END};
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ram_addr_o <= '0;
      ram_dq_o   <= '0;
    end else if (take_i) begin
      ram_addr_o <= req_addr_i;
      ram_dq_o   <= req_wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_valid_o <= 1'b0;
      rd_data_o  <= '0;
    end else begin
      rd_valid_o <= rd_done_i;
      if (rd_done_i) rd_data_o <= ram_dq_i;
    end
  end

endmodule

// File: rtl/sram_cycle_ctrl.sv
`timescale 1ns/1ps
module sram_cycle_ctrl import sram_ctrl_pkg::*; #(
  parameter int unsigned ADDR_W     = 21,
  parameter int unsigned DATA_W     = 8,
  parameter int unsigned CLK_PS     = 4000,
  parameter bit          SPEED_FAST = 1'b1,
  parameter int unsigned POWERUP_NS = 200000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              standby_i,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic              req_write_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  output logic              rd_valid_o,
  output logic [DATA_W-1:0] rd_data_o,
  output logic [ADDR_W-1:0] ram_addr_o,
  output logic              ram_ce_n_o,
  output logic              ram_ce_o,
  output logic              ram_oe_n_o,
  output logic              ram_we_n_o,
  output logic [DATA_W-1:0] ram_dq_o,
  output logic              ram_dq_oe_o,
  input  logic [DATA_W-1:0] ram_dq_i
);

  localparam int unsigned T_RC_NS  = SPEED_FAST ? 45 : 55;
  localparam int unsigned T_AA_NS  = SPEED_FAST ? 45 : 55;
  localparam int unsigned T_DOE_NS = SPEED_FAST ? 22 : 25;
  localparam int unsigned T_WP_NS  = SPEED_FAST ? 35 : 40;
  localparam int unsigned T_WC_NS  = SPEED_FAST ? 45 : 55;
  localparam int unsigned T_SD_NS  = 28;
  localparam int unsigned T_HZ_NS  = 18;

  localparam int unsigned RC_CYC  = ns2cyc(T_RC_NS, CLK_PS);
  localparam int unsigned RD_CYC  = maxu(maxu(RC_CYC, ns2cyc(T_AA_NS, CLK_PS)),
                                         ns2cyc(T_DOE_NS, CLK_PS));
  localparam int unsigned HZ_CYC  = ns2cyc(T_HZ_NS, CLK_PS);
  localparam int unsigned WP_CYC  = maxu(maxu(ns2cyc(T_WP_NS, CLK_PS),
                                              HZ_CYC + ns2cyc(T_SD_NS, CLK_PS)),
                                         ns2cyc(T_WC_NS, CLK_PS) - 1);
  localparam int unsigned PWR_CYC = ns2cyc(POWERUP_NS, CLK_PS);
  localparam int unsigned CNT_W   = $clog2(maxu(maxu(PWR_CYC, RD_CYC),
                                                maxu(WP_CYC, RC_CYC)) + 1);

  state_e state_d;
  logic   take;
  logic   rd_done;

  sram_cycle_fsm #(
    .CNT_W  (CNT_W),
    .PWR_CYC(PWR_CYC),
    .RD_CYC (RD_CYC),
    .HZ_CYC (HZ_CYC),
    .WP_CYC (WP_CYC),
    .RC_CYC (RC_CYC)
  ) i_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .standby_i  (standby_i),
    .req_valid_i(req_valid_i),
    .req_write_i(req_write_i),
    .req_ready_o(req_ready_o),
    .take_o     (take),
    .rd_done_o  (rd_done),
    .state_d_o  (state_d)
  );

  sram_pin_regs #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
  ) i_pins (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .state_d_i  (state_d),
    .take_i     (take),
    .rd_done_i  (rd_done),
    .req_addr_i (req_addr_i),
    .req_wdata_i(req_wdata_i),
    .ram_dq_i   (ram_dq_i),
    .ram_addr_o (ram_addr_o),
    .ram_ce_n_o (ram_ce_n_o),
    .ram_ce_o   (ram_ce_o),
    .ram_oe_n_o (ram_oe_n_o),
    .ram_we_n_o (ram_we_n_o),
    .ram_dq_o   (ram_dq_o),
    .ram_dq_oe_o(ram_dq_oe_o),
    .rd_valid_o (rd_valid_o),
    .rd_data_o  (rd_data_o)
  );

endmodule

// File: rtl/sram_cycle_ctrl_chk.sv
`timescale 1ns/1ps
module sram_cycle_ctrl_chk #(
  parameter int unsigned ADDR_W = 21
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_ready_o,
  input logic              rd_valid_o,
  input logic [ADDR_W-1:0] ram_addr_o,
  input logic              ram_ce_n_o,
  input logic              ram_ce_o,
  input logic              ram_oe_n_o,
  input logic              ram_we_n_o,
  input logic              ram_dq_oe_o
);

  a_r3_valid_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_valid_o |=> !rd_valid_o);

  a_r3_addr_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ram_ce_n_o && $past(!ram_ce_n_o)) |-> $stable(ram_addr_o));

  a_r4_we_needs_select: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ram_we_n_o |-> (!ram_ce_n_o && ram_ce_o));

  a_r5_drive_after_we_fall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ram_dq_oe_o) |-> (!ram_we_n_o && $past(!ram_we_n_o)));

  a_r5_drive_over_we_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ram_we_n_o) |-> ram_dq_oe_o);

  a_r5_drive_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ram_dq_oe_o) |-> $past(ram_we_n_o));

  a_r6_no_bus_fight: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ram_dq_oe_o |-> ram_oe_n_o);

  a_r6_oe_we_apart: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ram_oe_n_o |-> ram_we_n_o);

  a_r7_idle_deselect: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o |-> (ram_ce_n_o && !ram_ce_o && !ram_dq_oe_o));

endmodule

bind sram_cycle_ctrl sram_cycle_ctrl_chk #(
  .ADDR_W(ADDR_W)
) i_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .req_ready_o(req_ready_o),
  .rd_valid_o (rd_valid_o),
  .ram_addr_o (ram_addr_o),
  .ram_ce_n_o (ram_ce_n_o),
  .ram_ce_o   (ram_ce_o),
  .ram_oe_n_o (ram_oe_n_o),
  .ram_we_n_o (ram_we_n_o),
  .ram_dq_oe_o(ram_dq_oe_o)
);

// File: tb/test_sram_cycle_ctrl.sv
`timescale 1ns/1ps
module test_sram_cycle_ctrl;

  localparam int unsigned AW     = 4;
  localparam int unsigned DW     = 8;
  localparam int unsigned CLK_PS = 4000;
  localparam int unsigned PWR_NS = 400;
  localparam int unsigned NWORDS = 1 << AW;

  function automatic int unsigned cyc(int unsigned ns);
    int unsigned c;
    c = (ns * 1000 + CLK_PS - 1) / CLK_PS;
    return (c == 0) ? 1 : c;
  endfunction
  function automatic int unsigned mx(int unsigned a, int unsigned b);
    return (a > b) ? a : b;
  endfunction

  localparam int unsigned E_RD  = mx(cyc(45), cyc(22));
  localparam int unsigned E_HZ  = cyc(18);
  localparam int unsigned E_SD  = cyc(28);
  localparam int unsigned E_WP  = mx(mx(cyc(35), E_HZ + E_SD), cyc(45) - 1);
  localparam int unsigned E_TRC = cyc(45);
  localparam int unsigned E_PWR = cyc(PWR_NS);

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          standby_i = 1'b0;
  logic          req_valid_i = 1'b0;
  logic          req_ready_o;
  logic          req_write_i = 1'b0;
  logic [AW-1:0] req_addr_i = '0;
  logic [DW-1:0] req_wdata_i = '0;
  logic          rd_valid_o;
  logic [DW-1:0] rd_data_o;
  logic [AW-1:0] ram_addr_o;
  logic          ram_ce_n_o, ram_ce_o, ram_oe_n_o, ram_we_n_o, ram_dq_oe_o;
  logic [DW-1:0] ram_dq_o;
  logic [DW-1:0] ram_dq_i = 8'hEE;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2 clk_i = ~clk_i;

  sram_cycle_ctrl #(
    .ADDR_W(AW), .DATA_W(DW), .CLK_PS(CLK_PS), .SPEED_FAST(1'b1), .POWERUP_NS(PWR_NS)
  ) i_sram_cycle_ctrl (
    .clk_i(clk_i), .rst_ni(rst_ni), .standby_i(standby_i),
    .req_valid_i(req_valid_i), .req_ready_o(req_ready_o), .req_write_i(req_write_i),
    .req_addr_i(req_addr_i), .req_wdata_i(req_wdata_i),
    .rd_valid_o(rd_valid_o), .rd_data_o(rd_data_o),
    .ram_addr_o(ram_addr_o), .ram_ce_n_o(ram_ce_n_o), .ram_ce_o(ram_ce_o),
    .ram_oe_n_o(ram_oe_n_o), .ram_we_n_o(ram_we_n_o),
    .ram_dq_o(ram_dq_o), .ram_dq_oe_o(ram_dq_oe_o), .ram_dq_i(ram_dq_i)
  );

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  // behavioural RAM responder
  logic [DW-1:0] mem [NWORDS];
  logic          ram_rd;
  logic          rd_prev = 1'b0;
  logic          we_prev = 1'b1;
  logic [AW-1:0] addr_prev = '0;
  longint        t0 = 0;
  longint        t_rd_end = -1000;
  int            lo_cnt = 0;
  int            drv_cnt = 0;

  assign ram_rd = !ram_ce_n_o && ram_ce_o && ram_we_n_o && !ram_oe_n_o;

  always @(negedge clk_i) begin
    longint now;
    now = longint'($time);
    if (ram_rd) begin
      if (!rd_prev || ram_addr_o != addr_prev) t0 = now - 2;
      ram_dq_i <= (now - t0 >= 45) ? mem[ram_addr_o] : 8'hEE;
    end else begin
      ram_dq_i <= 8'hEE;
    end
    if (rd_prev && !ram_rd) t_rd_end = now - 2;
    if (ram_dq_oe_o)
      chk(!ram_rd && (now - t_rd_end >= 18), "R6 bus conflict", int'(now - t_rd_end), 18);
    if (!ram_we_n_o) begin
      lo_cnt++;
      if (ram_dq_oe_o) drv_cnt++;
    end
    if (!we_prev && ram_we_n_o) begin
      chk(lo_cnt == int'(E_WP), "R4 write pulse cycles", lo_cnt, int'(E_WP));
      chk(!ram_ce_n_o && ram_ce_o, "R4 select held after write", int'(ram_ce_o), 1);
      chk(lo_cnt - drv_cnt == int'(E_HZ), "R5 drive hold-off", lo_cnt - drv_cnt, int'(E_HZ));
      chk(drv_cnt >= int'(E_SD), "R5 data setup", drv_cnt, int'(E_SD));
      chk(ram_dq_oe_o, "R5 drive past write end", int'(ram_dq_oe_o), 1);
      mem[ram_addr_o] = ram_dq_o;
      lo_cnt = 0;
      drv_cnt = 0;
    end
    rd_prev   = ram_rd;
    we_prev   = ram_we_n_o;
    addr_prev = ram_addr_o;
  end

  function automatic logic [DW-1:0] pat1(int a);
    return DW'((a * 37 + 11) & 255);
  endfunction
  function automatic logic [DW-1:0] pat2(int a);
    return DW'((a * 91 + 200) & 255);
  endfunction

  // called at a falling edge; returns at a falling edge
  task automatic do_write(int a, logic [DW-1:0] d);
    int lat;
    req_valid_i = 1'b1; req_write_i = 1'b1;
    req_addr_i = AW'(a); req_wdata_i = d;
    while (!req_ready_o) @(negedge clk_i);
    @(negedge clk_i);
    req_valid_i = 1'b0;
    chk(!req_ready_o, "R9 busy after accept", int'(req_ready_o), 0);
    lat = 0;
    while (!req_ready_o) begin @(negedge clk_i); lat++; end
    chk(lat == int'(E_WP) + 1, "R6 write occupancy", lat, int'(E_WP) + 1);
  endtask

  task automatic do_read(int a, logic [DW-1:0] exp);
    int lat;
    req_valid_i = 1'b1; req_write_i = 1'b0; req_addr_i = AW'(a);
    while (!req_ready_o) @(negedge clk_i);
    @(negedge clk_i);
    req_valid_i = 1'b0;
    chk(!ram_oe_n_o && ram_we_n_o && !ram_ce_n_o, "R3 read controls", int'(ram_oe_n_o), 0);
    lat = 0;
    while (!rd_valid_o) begin @(negedge clk_i); lat++; end
    chk(lat == int'(E_RD), "R2 read length", lat, int'(E_RD));
    chk(rd_data_o == exp, "R10 read data", int'(rd_data_o), int'(exp));
    chk(req_ready_o && ram_ce_n_o, "R6 idle gap after read", int'(ram_ce_n_o), 1);
    @(negedge clk_i);
    chk(!rd_valid_o, "R3 valid pulse", int'(rd_valid_o), 0);
  endtask

  initial begin
    repeat (50000) @(posedge clk_i);
    failures++;
    $display("FAIL watchdog expired actual=0 expected=1");
    finish_run();
  end

  initial begin
    int bad;
    for (int i = 0; i < int'(NWORDS); i++) mem[i] = 8'h00;
    repeat (3) @(negedge clk_i);
    chk(ram_ce_n_o && !ram_ce_o && ram_oe_n_o && ram_we_n_o && !ram_dq_oe_o && !rd_valid_o,
        "R1 reset pins", int'(ram_ce_n_o), 1);
    rst_ni = 1'b1;
    // request held during power-up must be ignored
    req_valid_i = 1'b1; req_write_i = 1'b1; req_addr_i = 3; req_wdata_i = 8'h55;
    bad = 0;
    for (int k = 1; k < int'(E_PWR); k++) begin
      @(negedge clk_i);
      if (req_ready_o || !ram_ce_n_o || ram_ce_o || !ram_we_n_o) bad++;
    end
    chk(bad == 0, "R1 power-up hold-off", bad, 0);
    @(negedge clk_i);
    req_valid_i = 1'b0;
    chk(req_ready_o, "R1 ready after power-up", int'(req_ready_o), 1);
    chk(ram_ce_n_o, "R7 idle standby", int'(ram_ce_n_o), 1);

    // sweep: fill, read back, then write/read interleaved
    for (int a = 0; a < int'(NWORDS); a++) do_write(a, pat1(a));
    for (int a = 0; a < int'(NWORDS); a++) do_read(a, pat1(a));
    for (int a = int'(NWORDS) - 1; a >= 0; a--) begin
      do_write(a, pat2(a));
      do_read(a, pat2(a));
    end
    do_read(3, pat2(3));

    // standby: requests refused and ignored
    standby_i = 1'b1;
    #0;
    chk(!req_ready_o, "R7 ready low in standby", int'(req_ready_o), 0);
    req_valid_i = 1'b1; req_write_i = 1'b1; req_addr_i = 0; req_wdata_i = 8'hFF;
    bad = 0;
    for (int k = 0; k < 8; k++) begin
      @(negedge clk_i);
      if (req_ready_o || !ram_ce_n_o || ram_ce_o || !ram_we_n_o) bad++;
    end
    chk(bad == 0, "R7 standby ignores request", bad, 0);
    req_valid_i = 1'b0;
    standby_i = 1'b0;
    repeat (E_TRC) @(negedge clk_i);
    chk(!req_ready_o, "R8 recovery hold", int'(req_ready_o), 0);
    @(negedge clk_i);
    chk(req_ready_o, "R8 ready after recovery", int'(req_ready_o), 1);
    do_read(0, pat2(0));

    finish_run();
  end

endmodule